// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control state of one downstream port of a root hub. A single 32-bit word is both read and written, but the two directions mean different things. A read returns the live port state and a set of latched change flags. A write is a set of one-bit commands. A 1 in a low bit asks for an action on enable, suspend, reset or power. A 1 in a high bit acknowledges a change flag and clears it. A 0 anywhere does nothing.

A simplified port model drives four plain inputs: device attached, low-speed device, over-current, and a one-cycle pulse that ends a port reset. The block drives four control levels back to that model: enable, suspend, reset and power. All state updates on the rising clock edge. A write is taken in the cycle `wr_en` is high, and its effect shows in `rd_data` after that edge. The read word is built from registers only, so the port inputs reach it one cycle after they change.

Top module: `rh_port_status_reg`

## Requirements
- R1: After reset, `rd_data` is zero and all four control outputs are low.
- R2: Read bit 0 shows the connect input, bit 3 the over-current input and bit 9 the low-speed input, each one cycle late. Bits 1, 2, 4 and 8 show the enable, suspend, reset and power outputs.
- R3: Writing 1 to bit 0 clears enable and writing 1 to bit 1 sets it. If both are written together, the clear wins.
- R4: Writing 1 to bit 2 sets suspend and writing 1 to bit 3 clears it. If both are written together, the clear wins.
- R5: Writing 1 to bit 4 starts a port reset. A completion pulse that arrives while reset is active clears reset, sets enable and sets the reset-change flag at bit 20.
- R6: Writing 1 to bit 8 turns power on and writing 1 to bit 9 turns it off. If both are written together, power goes off.
- R7: Any change of the connect input sets the connect-change flag at bit 16.
- R8: While read bit 0 is 0, writes of 1 to bits 1, 2 or 4 change nothing, and the connect-change flag is set instead.
- R9: While the over-current input is high, enable is forced clear. If enable was set, the enable-change flag at bit 17 is set. Any change of the over-current input sets the over-current-change flag at bit 19.
- R10: A write of 1 to bit 3 while suspended sets the suspend-change flag at bit 18.
- R11: Writing 1 to any of bits 16 to 20 clears that flag. A flag event in the same cycle wins over the clear. Bits written 0 leave every flag and every control unchanged.
- R12: Bits 5 to 7, 10 to 15 and 21 to 31 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word (1 = act, 0 = no effect) |
| rd_data | output | 32 | Status word with change flags |
| dev_conn_i | input | 1 | Device attached on the port |
| dev_lowspd_i | input | 1 | Attached device is low speed |
| ovc_i | input | 1 | Over-current condition |
| rst_done_i | input | 1 | One-cycle pulse: port reset finished |
| port_en_o | output | 1 | Port enable control |
| port_susp_o | output | 1 | Port suspend control |
| port_rst_o | output | 1 | Port reset control |
| port_pwr_o | output | 1 | Port power control |

## Verification
The bench aims at the cycles where a hardware event and a software acknowledge hit the same flag. A design that let the clear win there would lose a connect or over-current event. It writes conflicting set and clear bits in one word, and a design with the wrong priority would leave a port enabled, suspended or powered after a clear. It issues enable, suspend and reset commands with no device attached. A design without the connect gate would drive the port anyway and never raise the connect-change flag. It also gives completion pulses outside a reset and raises over-current during a reset completion. A wrong design there would enable a port that is not resetting, or one that is in over-current.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  // command positions on write
  localparam int unsigned W_CLR_EN  = 0;
  localparam int unsigned W_SET_EN  = 1;
  localparam int unsigned W_SET_SU  = 2;
  localparam int unsigned W_CLR_SU  = 3;
  localparam int unsigned W_SET_RS  = 4;
  localparam int unsigned W_PWR_ON  = 8;
  localparam int unsigned W_PWR_OFF = 9;
  // status positions on read
  localparam int unsigned R_CONN    = 0;
  localparam int unsigned R_EN      = 1;
  localparam int unsigned R_SU      = 2;
  localparam int unsigned R_OVC     = 3;
  localparam int unsigned R_RS      = 4;
  localparam int unsigned R_PWR     = 8;
  localparam int unsigned R_LS      = 9;
  // change flags
  localparam int unsigned CHG_BASE  = 16;
  localparam int unsigned NUM_CHG   = 5;
  localparam int unsigned CF_CONN   = 0;
  localparam int unsigned CF_EN     = 1;
  localparam int unsigned CF_SU     = 2;
  localparam int unsigned CF_OVC    = 3;
  localparam int unsigned CF_RS     = 4;

  typedef struct packed {
    logic               clr_en;
    logic               set_en;
    logic               set_su;
    logic               clr_su;
    logic               start_rs;
    logic               pwr_on;
    logic               pwr_off;
    logic               blocked;
    logic [NUM_CHG-1:0] chg_ack;
  } port_cmd_t;
endpackage

// File: rtl/rh_port_sample.sv
module rh_port_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_i,
  input  logic ls_i,
  input  logic ovc_i,
  output logic conn_q,
  output logic ls_q,
  output logic ovc_q,
  output logic conn_evt,
  output logic ovc_evt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      ls_q   <= 1'b0;
      ovc_q  <= 1'b0;
    end else begin
      conn_q <= conn_i;
      ls_q   <= ls_i;
      ovc_q  <= ovc_i;
    end
  end

  assign conn_evt = conn_i ^ conn_q;
  assign ovc_evt  = ovc_i ^ ovc_q;

  p_conn_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conn_i |=> conn_q);
endmodule

// File: rtl/rh_port_cmd_dec.sv
module rh_port_cmd_dec
  import rh_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              conn_q,
  output port_cmd_t         cmd
);
  localparam int unsigned CHG_TOP = CHG_BASE + NUM_CHG - 1;

  logic [DATA_W-1:0] w;
  logic              want_attach;

  assign w = wr_en ? wr_data : '0;
  assign want_attach = w[W_SET_EN] | w[W_SET_SU] | w[W_SET_RS];

  always_comb begin
    cmd          = '0;
    cmd.clr_en   = w[W_CLR_EN];
    cmd.set_en   = w[W_SET_EN] & conn_q;
    cmd.set_su   = w[W_SET_SU] & conn_q;
    cmd.clr_su   = w[W_CLR_SU];
    cmd.start_rs = w[W_SET_RS] & conn_q;
    cmd.pwr_on   = w[W_PWR_ON];
    cmd.pwr_off  = w[W_PWR_OFF];
    cmd.blocked  = want_attach & ~conn_q;
    cmd.chg_ack  = w[CHG_TOP:CHG_BASE];
  end

  logic unused_bits;
  assign unused_bits = ^{w[DATA_W-1:CHG_TOP+1], w[CHG_BASE-1:W_PWR_OFF+1], w[7:5]};
endmodule

// File: rtl/rh_port_ctl.sv
module rh_port_ctl
  import rh_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_cmd_t cmd,
  input  logic      ovc_i,
  input  logic      done_i,
  output logic      en_q,
  output logic      su_q,
  output logic      rs_q,
  output logic      pw_q,
  output logic      en_lost,
  output logic      su_left,
  output logic      rs_fin
);
  assign rs_fin  = done_i & rs_q;
  assign en_lost = ovc_i & en_q;
  assign su_left = cmd.clr_su & su_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      su_q <= 1'b0;
      rs_q <= 1'b0;
      pw_q <= 1'b0;
    end else begin
      // enable: over-current, then software clear, then sets
      if (ovc_i || cmd.clr_en) en_q <= 1'b0;
      else if (cmd.set_en || rs_fin) en_q <= 1'b1;
      // suspend: clear wins
      if (cmd.clr_su) su_q <= 1'b0;
      else if (cmd.set_su) su_q <= 1'b1;
      // reset: completion wins over a new start
      if (rs_fin) rs_q <= 1'b0;
      else if (cmd.start_rs) rs_q <= 1'b1;
      // power: off wins
      if (cmd.pwr_off) pw_q <= 1'b0;
      else if (cmd.pwr_on) pw_q <= 1'b1;
    end
  end

  p_ovc_clears_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_i |=> !en_q);
  p_rst_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_q && done_i && !ovc_i && !cmd.clr_en) |=> (en_q && !rs_q));
  p_pwr_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.pwr_off |=> !pw_q);
  p_su_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr_su |=> !su_q);
endmodule

// File: rtl/rh_port_chg.sv
module rh_port_chg #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ack,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
      else if (ack[i]) flag[i] <= 1'b0;
    end

    p_evt_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && !ack[i]) |=> $stable(flag[i]));
  end
endmodule

// File: rtl/rh_port_status_reg.sv
module rh_port_status_reg
  import rh_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dev_conn_i,
  input  logic              dev_lowspd_i,
  input  logic              ovc_i,
  input  logic              rst_done_i,
  output logic              port_en_o,
  output logic              port_susp_o,
  output logic              port_rst_o,
  output logic              port_pwr_o
);
  localparam int unsigned MIN_W = CHG_BASE + NUM_CHG;

  logic              conn_q, ls_q, ovc_q, conn_evt, ovc_evt;
  logic              en_lost, su_left, rs_fin;
  logic [NUM_CHG-1:0] chg_evt, chg_flag;
  port_cmd_t         cmd;

  rh_port_sample u_smp (
    .clk(clk), .rst_n(rst_n),
    .conn_i(dev_conn_i), .ls_i(dev_lowspd_i), .ovc_i(ovc_i),
    .conn_q(conn_q), .ls_q(ls_q), .ovc_q(ovc_q),
    .conn_evt(conn_evt), .ovc_evt(ovc_evt)
  );

  rh_port_cmd_dec #(.DATA_W(DATA_W)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .conn_q(conn_q), .cmd(cmd)
  );

  rh_port_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .ovc_i(ovc_i), .done_i(rst_done_i),
    .en_q(port_en_o), .su_q(port_susp_o), .rs_q(port_rst_o), .pw_q(port_pwr_o),
    .en_lost(en_lost), .su_left(su_left), .rs_fin(rs_fin)
  );

  always_comb begin
    chg_evt          = '0;
    chg_evt[CF_CONN] = conn_evt | cmd.blocked;
    chg_evt[CF_EN]   = en_lost;
    chg_evt[CF_SU]   = su_left;
    chg_evt[CF_OVC]  = ovc_evt;
    chg_evt[CF_RS]   = rs_fin;
  end

  rh_port_chg #(.N(NUM_CHG)) u_chg (
    .clk(clk), .rst_n(rst_n), .evt(chg_evt), .ack(cmd.chg_ack), .flag(chg_flag)
  );

  always_comb begin
    rd_data                              = '0;
    rd_data[R_CONN]                      = conn_q;
    rd_data[R_EN]                        = port_en_o;
    rd_data[R_SU]                        = port_susp_o;
    rd_data[R_OVC]                       = ovc_q;
    rd_data[R_RS]                        = port_rst_o;
    rd_data[R_PWR]                       = port_pwr_o;
    rd_data[R_LS]                        = ls_q;
    rd_data[CHG_BASE +: NUM_CHG]         = chg_flag;
  end

  initial begin
    if (DATA_W < MIN_W) $error("DATA_W too narrow for change flags");
  end

  p_no_attach_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[W_SET_RS] && !rd_data[R_CONN] && !port_rst_o) |=> !port_rst_o);
  p_no_attach_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[W_SET_EN] && !rd_data[R_CONN]) |=> rd_data[CHG_BASE+CF_CONN]);
  p_rst_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst_o && rst_done_i) |=> rd_data[CHG_BASE+CF_RS]);
endmodule

// File: tb/rh_port_status_reg_test.sv
module rh_port_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        conn = 1'b0, ls = 1'b0, ovc = 1'b0, done = 1'b0;
  logic        en_o, su_o, rs_o, pw_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // bench model state
  logic m_conn, m_ls, m_ovc, m_en, m_su, m_rs, m_pw;
  logic [4:0] m_chg;

  always #4 clk = ~clk;

  rh_port_status_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_conn_i(conn), .dev_lowspd_i(ls), .ovc_i(ovc), .rst_done_i(done),
    .port_en_o(en_o), .port_susp_o(su_o), .port_rst_o(rs_o), .port_pwr_o(pw_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at cycle %0d", req, got, exp, cycles);
    end
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] r = '0;
    r[0] = m_conn; r[1] = m_en; r[2] = m_su; r[3] = m_ovc; r[4] = m_rs;
    r[8] = m_pw; r[9] = m_ls; r[20:16] = m_chg;
    return r;
  endfunction

  task automatic model_reset();
    m_conn = 0; m_ls = 0; m_ovc = 0; m_en = 0; m_su = 0; m_rs = 0; m_pw = 0; m_chg = '0;
  endtask

  task automatic model_step(input logic w, input logic [31:0] d, input logic c,
                            input logic l, input logic o, input logic dn);
    logic [31:0] wc = w ? d : 32'h0;
    logic ok = m_conn;
    logic dv = dn & m_rs;
    logic [4:0] ev = '0;
    logic n_en = m_en, n_su = m_su, n_rs = m_rs, n_pw = m_pw;
    ev[0] = (c != m_conn) | (~ok & (wc[1] | wc[2] | wc[4]));
    ev[1] = m_en & o;
    ev[2] = wc[3] & m_su;
    ev[3] = (o != m_ovc);
    ev[4] = dv;
    if (o || wc[0]) n_en = 0; else if ((wc[1] && ok) || dv) n_en = 1;
    if (wc[3]) n_su = 0; else if (wc[2] && ok) n_su = 1;
    if (dv) n_rs = 0; else if (wc[4] && ok) n_rs = 1;
    if (wc[9]) n_pw = 0; else if (wc[8]) n_pw = 1;
    m_chg = ev | (m_chg & ~wc[20:16]);
    m_en = n_en; m_su = n_su; m_rs = n_rs; m_pw = n_pw;
    m_conn = c; m_ls = l; m_ovc = o;
  endtask

  task automatic compare_all();
    logic [31:0] e = exp_word();
    check("R2", {28'h0, rd_data[9], rd_data[3], rd_data[0], 1'b0}, {28'h0, e[9], e[3], e[0], 1'b0});
    check("R3", {31'h0, en_o}, {31'h0, m_en});
    check("R4", {31'h0, su_o}, {31'h0, m_su});
    check("R5", {30'h0, rs_o, rd_data[20]}, {30'h0, m_rs, m_chg[4]});
    check("R6", {31'h0, pw_o}, {31'h0, m_pw});
    check("R7", {31'h0, rd_data[16]}, {31'h0, m_chg[0]});
    check("R9", {30'h0, rd_data[19], rd_data[17]}, {30'h0, m_chg[3], m_chg[1]});
    check("R10", {31'h0, rd_data[18]}, {31'h0, m_chg[2]});
    check("R12", rd_data & 32'hFFE0_FCE0, 32'h0);
  endtask

  // one cycle: called at a falling edge
  task automatic cyc(input logic w, input logic [31:0] d, input logic c,
                     input logic l, input logic o, input logic dn);
    wr_en = w; wr_data = d; conn = c; ls = l; ovc = o; done = dn;
    @(posedge clk);
    model_step(w, d, c, l, o, dn);
    #2;
    compare_all();
    @(negedge clk);
    wr_en = 0; done = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin : main
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", rd_data, 32'h0);
    check("R1", {28'h0, en_o, su_o, rs_o, pw_o}, 32'h0);
    rst_n = 1'b1;

    // R8: no device attached, attach-dependent commands refused
    cyc(1, 32'h0000_0016, 0, 0, 0, 0);
    check("R8", {29'h0, en_o, su_o, rs_o}, 32'h0);
    check("R8", {31'h0, rd_data[16]}, 32'h1);
    // R11: write of zeros changes nothing
    cyc(1, 32'h0, 0, 0, 0, 0);
    check("R11", {31'h0, rd_data[16]}, 32'h1);
    // R11: acknowledge clears
    cyc(1, 32'h0001_0000, 0, 0, 0, 0);
    check("R11", {31'h0, rd_data[16]}, 32'h0);
    // attach, then acknowledge in the same cycle as a detach: event wins (R11)
    cyc(0, 0, 1, 1, 0, 0);
    cyc(1, 32'h0001_0000, 0, 1, 0, 0);
    check("R11", {31'h0, rd_data[16]}, 32'h1);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(1, 32'h001F_0000, 1, 0, 0, 0);
    // R5: reset, completion pulse
    cyc(1, 32'h0000_0110, 1, 0, 0, 0);
    check("R5", {30'h0, rs_o, en_o}, 32'h2);
    cyc(0, 0, 1, 0, 0, 1);
    check("R5", {30'h0, rs_o, en_o}, 32'h1);
    // R3: clear wins over set
    cyc(1, 32'h0000_0003, 1, 0, 0, 0);
    check("R3", {31'h0, en_o}, 32'h0);
    // R4 / R10: suspend then resume
    cyc(1, 32'h0000_0006, 1, 0, 0, 0);
    cyc(1, 32'h0000_0008, 1, 0, 0, 0);
    check("R10", {31'h0, rd_data[18]}, 32'h1);
    // R9: over-current while enabled
    cyc(1, 32'h0000_0002, 1, 0, 1, 0);
    check("R9", {30'h0, en_o, rd_data[19]}, 32'h1);
    // R6: on and off together
    cyc(1, 32'h0000_0300, 1, 0, 0, 0);
    check("R6", {31'h0, pw_o}, 32'h0);
    // completion pulse outside a reset does nothing (R5)
    cyc(1, 32'h001F_0000, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 1);
    check("R5", {30'h0, en_o, rd_data[20]}, 32'h0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic w = $urandom_range(0, 1) == 1;
      logic [31:0] d = $urandom() & 32'h001F_031F;
      logic c = conn, o = ovc, l = ls, dn;
      if ($urandom_range(0, 7) == 0) d = d | ($urandom() & 32'hFFE0_FCE0);
      if ($urandom_range(0, 15) == 0) c = ~c;
      if ($urandom_range(0, 31) == 0) o = ~o;
      if ($urandom_range(0, 15) == 0) l = ~l;
      dn = rs_o ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 31) == 0);
      cyc(w, d, c, l, o, dn);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule